// File: doc/BRIEF.md
# Vector Instruction Sequencer

This control block takes 32-bit instruction words from an instruction queue and turns each one into a run of per-element register-file accesses. A word holds an opcode in bits [7:0] and three operand fields: op1 in [15:8], which names the destination or the single addressed vector, then op2 in [23:16] and op3 in [31:24], which name the sources. Once a word is accepted, an element counter walks elements 0 to 31. In each cycle the block drives the read indices and the element index toward the register files, the opcode toward the lanes, and, one cycle later, the write-back strobe and address.

Operations that combine a vector with a scalar read the scalar file only once, on the first element, and flag the lanes to broadcast that value. Compare-type operations produce one bit per element, so their writes go to the predicate file instead of the vector file. Single-element loads and stores come from the bus bridge. Each one touches exactly one element, named by op2, without walking the counter. Words with an unknown opcode or an out-of-range register or element index are consumed and dropped.

The block takes a new word only when it is idle. It raises a one-cycle completion pulse after the last element of an instruction is written.

Top module: `vec_sequencer`

## Requirements
- R1: After reset, `instr_ready` is 1 and `rd_valid`, `srf_rd_en`, `vrf_we`, `prf_we` and `done` are 0.
- R2: `instr_ready` is 1 only while no instruction is being processed. A word is consumed on a rising edge where both `instr_valid` and `instr_ready` are 1. For a full-vector instruction, `instr_ready` stays 0 from the cycle after acceptance until the cycle in which `done` is raised.
- R3: Full-vector classes are: vector–vector (opcodes 0x02-0x04, 0x07-0x0B, 0x10), vector–scalar (0x05, 0x06, 0x15, 0x16) and all predicate-writing opcodes. For these, `rd_valid` is 1 for exactly 32 consecutive cycles, starting one cycle after acceptance. `rd_elem` runs 0 to 31 over those cycles and `lane_op` equals the opcode.
- R4: For vector–vector opcodes, `rd_reg1` is op2 and `rd_reg2` is op3. Every read cycle is followed one cycle later by `vrf_we` = 1, with `vrf_wr_reg` equal to op1 and `vrf_wr_elem` equal to that read's element.
- R5: For vector–scalar opcodes, `srf_rd_en` is 1 only in the first read cycle, with `srf_rd_reg` equal to op3. `lane_scalar` is 1 on all 32 read cycles, `rd_reg1` is op2, `rd_reg2` is 0, and the results are written to the vector file as in R4.
- R6: Predicate-writing opcodes are 0x0C-0x0F, 0x14 and 0x17-0x1A. They strobe `prf_we`, never `vrf_we`, with `prf_wr_reg` equal to op1 and one write per element. Opcodes 0x14 and 0x17 read predicate sources: `rd_src_pred` = 1, `rd_reg1` = op2, `rd_reg2` = op3. Opcodes 0x0F and 0x18-0x1A read two vector sources (op2, op3). Opcodes 0x0C-0x0E read one vector source (op2) with `rd_reg2` = 0.
- R7: Opcode 0x00 (element load) and 0x01 (element store) give a single read cycle with `rd_reg1` = op1, `rd_elem` = op2 and `lane_op` equal to the opcode. A load then writes the vector file once at register op1, element op2. A store writes nothing.
- R8: `done` is a one-cycle pulse. It is raised 34 cycles after acceptance for full-vector instructions and 3 cycles after acceptance for loads and stores. The next word can be accepted in that same cycle.
- R9: A word is discarded if its opcode is outside all of the classes above. It is also discarded if any index it uses is out of range: a vector index of 6 or more, a scalar index of 6 or more, a predicate index of 6 or more, or a load/store element of 32 or more. A discarded word is consumed, produces no read, no write and no `done`, and `instr_ready` stays 1.
- R10: `vrf_we` and `prf_we` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction queue has a word |
| instr_word | input | 32 | Instruction word |
| instr_ready | output | 1 | Sequencer is idle and pops the word |
| rd_valid | output | 1 | Read addresses and lane opcode are valid |
| rd_elem | output | 5 | Element index of the current read |
| rd_reg1 | output | 3 | First source register index |
| rd_reg2 | output | 3 | Second source register index |
| rd_src_pred | output | 1 | Sources are taken from the predicate file |
| lane_op | output | 8 | Opcode sent to the lanes |
| lane_scalar | output | 1 | Lanes use the broadcast scalar as second operand |
| srf_rd_en | output | 1 | Scalar file read strobe |
| srf_rd_reg | output | 3 | Scalar register index |
| vrf_we | output | 1 | Vector file write strobe |
| vrf_wr_reg | output | 3 | Vector destination register |
| vrf_wr_elem | output | 5 | Vector destination element |
| prf_we | output | 1 | Predicate file write strobe |
| prf_wr_reg | output | 3 | Predicate destination register |
| prf_wr_elem | output | 5 | Predicate destination bit index |
| done | output | 1 | Instruction completed |

## Verification
A counter that skips or stalls shows up at once at the ports: the read that follows carries the wrong `rd_elem`, and one cycle later the write lands on the wrong element. A mis-sized run changes how many writes are seen and when `done` appears. A mis-decoded class sends writes to the wrong file, or moves the scalar strobe, within the first two cycles after acceptance. A state machine that fails to return to idle shows as a missing `done` and a stuck-low `instr_ready`. The bench sweeps every 8-bit opcode with varied in-range indices and then drives out-of-range indices, comparing each cycle against expected values computed from the opcode class.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  typedef enum logic [2:0] {
    CL_NONE, CL_VV, CL_VS, CL_PV1, CL_PV2, CL_PP, CL_LD, CL_ST
  } op_class_e;

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_DONE} seq_state_e;

  function automatic op_class_e classify(input logic [7:0] op);
    case (op)
      8'h00: return CL_LD;
      8'h01: return CL_ST;
      8'h02, 8'h03, 8'h04, 8'h07, 8'h08,
      8'h09, 8'h0A, 8'h0B, 8'h10: return CL_VV;
      8'h05, 8'h06, 8'h15, 8'h16: return CL_VS;
      8'h0C, 8'h0D, 8'h0E: return CL_PV1;
      8'h0F, 8'h18, 8'h19, 8'h1A: return CL_PV2;
      8'h14, 8'h17: return CL_PP;
      default: return CL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/vseq_decode.sv
module vseq_decode
  import vseq_pkg::*;
#(
  parameter int NUM_VREG = 6,
  parameter int NUM_SREG = 6,
  parameter int NUM_PREG = 6,
  parameter int ELEMS    = 32,
  parameter int REG_W    = 3,
  parameter int ELEM_W   = 5
) (
  input  logic [31:0]       word,
  output op_class_e         cls,
  output logic              legal,
  output logic [7:0]        opcode,
  output logic [REG_W-1:0]  dst,
  output logic [REG_W-1:0]  src1,
  output logic [REG_W-1:0]  src2,
  output logic [ELEM_W-1:0] elem
);
  localparam logic [7:0] NV8 = 8'(NUM_VREG);
  localparam logic [7:0] NS8 = 8'(NUM_SREG);
  localparam logic [7:0] NP8 = 8'(NUM_PREG);
  localparam logic [7:0] NE8 = 8'(ELEMS);

  logic [7:0] f1, f2, f3;

  assign opcode = word[7:0];
  assign f1     = word[15:8];
  assign f2     = word[23:16];
  assign f3     = word[31:24];
  assign dst    = f1[REG_W-1:0];
  assign src1   = f2[REG_W-1:0];
  assign src2   = f3[REG_W-1:0];
  assign elem   = f2[ELEM_W-1:0];

  always_comb begin
    cls = classify(opcode);
    case (cls)
      CL_VV:        legal = (f1 < NV8) && (f2 < NV8) && (f3 < NV8);
      CL_VS:        legal = (f1 < NV8) && (f2 < NV8) && (f3 < NS8);
      CL_PV1:       legal = (f1 < NP8) && (f2 < NV8);
      CL_PV2:       legal = (f1 < NP8) && (f2 < NV8) && (f3 < NV8);
      CL_PP:        legal = (f1 < NP8) && (f2 < NP8) && (f3 < NP8);
      CL_LD, CL_ST: legal = (f1 < NV8) && (f2 < NE8);
      default:      legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/vseq_issue.sv
module vseq_issue
  import vseq_pkg::*;
#(
  parameter int ELEMS  = 32,
  parameter int REG_W  = 3,
  parameter int ELEM_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic              legal,
  input  op_class_e         cls,
  input  logic [7:0]        opcode,
  input  logic [REG_W-1:0]  dst,
  input  logic [REG_W-1:0]  src1,
  input  logic [REG_W-1:0]  src2,
  input  logic [ELEM_W-1:0] elem,
  input  logic              wb_last,
  output logic              instr_ready,
  output logic              rd_valid,
  output logic [ELEM_W-1:0] rd_elem,
  output logic [REG_W-1:0]  rd_reg1,
  output logic [REG_W-1:0]  rd_reg2,
  output logic              rd_src_pred,
  output logic [7:0]        lane_op,
  output logic              lane_scalar,
  output logic              srf_rd_en,
  output logic [REG_W-1:0]  srf_rd_reg,
  output logic              rd_last,
  output logic [REG_W-1:0]  rd_dst,
  output logic              rd_wr_vec,
  output logic              rd_wr_pred,
  output logic              done
);
  localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(ELEMS - 1);

  seq_state_e        state;
  op_class_e         q_cls;
  logic [7:0]        q_op;
  logic [REG_W-1:0]  q_dst, q_s1, q_s2;
  logic [ELEM_W-1:0] cnt;
  logic              single, last, two_src;

  assign instr_ready = (state == S_IDLE);
  assign single      = (q_cls == CL_LD) || (q_cls == CL_ST);
  assign last        = single || (cnt == LAST_ELEM);
  assign two_src     = (q_cls == CL_VV) || (q_cls == CL_PV2) || (q_cls == CL_PP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      q_cls       <= CL_NONE;
      q_op        <= '0;
      q_dst       <= '0;
      q_s1        <= '0;
      q_s2        <= '0;
      cnt         <= '0;
      rd_valid    <= 1'b0;
      rd_elem     <= '0;
      rd_reg1     <= '0;
      rd_reg2     <= '0;
      rd_src_pred <= 1'b0;
      lane_op     <= '0;
      lane_scalar <= 1'b0;
      srf_rd_en   <= 1'b0;
      srf_rd_reg  <= '0;
      rd_last     <= 1'b0;
      rd_dst      <= '0;
      rd_wr_vec   <= 1'b0;
      rd_wr_pred  <= 1'b0;
      done        <= 1'b0;
    end else begin
      done      <= 1'b0;
      srf_rd_en <= 1'b0;
      case (state)
        S_IDLE: begin
          rd_valid <= 1'b0;
          if (instr_valid && legal) begin
            q_cls <= cls;
            q_op  <= opcode;
            q_dst <= dst;
            q_s1  <= src1;
            q_s2  <= src2;
            cnt   <= (cls == CL_LD || cls == CL_ST) ? elem : '0;
            state <= S_EXEC;
          end
        end
        S_EXEC: begin
          rd_valid    <= 1'b1;
          rd_elem     <= cnt;
          rd_reg1     <= single ? q_dst : q_s1;
          rd_reg2     <= two_src ? q_s2 : '0;
          rd_src_pred <= (q_cls == CL_PP);
          lane_op     <= q_op;
          lane_scalar <= (q_cls == CL_VS);
          srf_rd_en   <= (q_cls == CL_VS) && (cnt == '0);
          srf_rd_reg  <= q_s2;
          rd_last     <= last;
          rd_dst      <= q_dst;
          rd_wr_vec   <= (q_cls == CL_VV) || (q_cls == CL_VS) || (q_cls == CL_LD);
          rd_wr_pred  <= (q_cls == CL_PV1) || (q_cls == CL_PV2) || (q_cls == CL_PP);
          if (last) state <= S_DONE;
          else      cnt   <= cnt + 1'b1;
        end
        default: begin
          rd_valid <= 1'b0;
          if (wb_last) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/vseq_wb.sv
module vseq_wb #(
  parameter int REG_W  = 3,
  parameter int ELEM_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_valid,
  input  logic              rd_last,
  input  logic              rd_wr_vec,
  input  logic              rd_wr_pred,
  input  logic [REG_W-1:0]  rd_dst,
  input  logic [ELEM_W-1:0] rd_elem,
  output logic              vrf_we,
  output logic [REG_W-1:0]  vrf_wr_reg,
  output logic [ELEM_W-1:0] vrf_wr_elem,
  output logic              prf_we,
  output logic [REG_W-1:0]  prf_wr_reg,
  output logic [ELEM_W-1:0] prf_wr_elem,
  output logic              wb_last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vrf_we      <= 1'b0;
      prf_we      <= 1'b0;
      wb_last     <= 1'b0;
      vrf_wr_reg  <= '0;
      vrf_wr_elem <= '0;
      prf_wr_reg  <= '0;
      prf_wr_elem <= '0;
    end else begin
      vrf_we      <= rd_valid && rd_wr_vec;
      prf_we      <= rd_valid && rd_wr_pred;
      wb_last     <= rd_valid && rd_last;
      vrf_wr_reg  <= rd_dst;
      vrf_wr_elem <= rd_elem;
      prf_wr_reg  <= rd_dst;
      prf_wr_elem <= rd_elem;
    end
  end
endmodule

// File: rtl/vec_sequencer.sv
module vec_sequencer
  import vseq_pkg::*;
#(
  parameter int NUM_VREG = 6,
  parameter int NUM_SREG = 6,
  parameter int NUM_PREG = 6,
  parameter int ELEMS    = 32,
  parameter int REG_W    = 3,
  parameter int ELEM_W   = $clog2(ELEMS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [31:0]       instr_word,
  output logic              instr_ready,
  output logic              rd_valid,
  output logic [ELEM_W-1:0] rd_elem,
  output logic [REG_W-1:0]  rd_reg1,
  output logic [REG_W-1:0]  rd_reg2,
  output logic              rd_src_pred,
  output logic [7:0]        lane_op,
  output logic              lane_scalar,
  output logic              srf_rd_en,
  output logic [REG_W-1:0]  srf_rd_reg,
  output logic              vrf_we,
  output logic [REG_W-1:0]  vrf_wr_reg,
  output logic [ELEM_W-1:0] vrf_wr_elem,
  output logic              prf_we,
  output logic [REG_W-1:0]  prf_wr_reg,
  output logic [ELEM_W-1:0] prf_wr_elem,
  output logic              done
);
  op_class_e         d_cls;
  logic              d_legal;
  logic [7:0]        d_op;
  logic [REG_W-1:0]  d_dst, d_s1, d_s2;
  logic [ELEM_W-1:0] d_elem;
  logic              rd_last, rd_wr_vec, rd_wr_pred, wb_last;
  logic [REG_W-1:0]  rd_dst;

  vseq_decode #(
    .NUM_VREG(NUM_VREG), .NUM_SREG(NUM_SREG), .NUM_PREG(NUM_PREG),
    .ELEMS(ELEMS), .REG_W(REG_W), .ELEM_W(ELEM_W)
  ) u_decode (
    .word(instr_word), .cls(d_cls), .legal(d_legal), .opcode(d_op),
    .dst(d_dst), .src1(d_s1), .src2(d_s2), .elem(d_elem)
  );

  vseq_issue #(.ELEMS(ELEMS), .REG_W(REG_W), .ELEM_W(ELEM_W)) u_issue (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .legal(d_legal),
    .cls(d_cls), .opcode(d_op), .dst(d_dst), .src1(d_s1), .src2(d_s2),
    .elem(d_elem), .wb_last(wb_last), .instr_ready(instr_ready),
    .rd_valid(rd_valid), .rd_elem(rd_elem), .rd_reg1(rd_reg1),
    .rd_reg2(rd_reg2), .rd_src_pred(rd_src_pred), .lane_op(lane_op),
    .lane_scalar(lane_scalar), .srf_rd_en(srf_rd_en),
    .srf_rd_reg(srf_rd_reg), .rd_last(rd_last), .rd_dst(rd_dst),
    .rd_wr_vec(rd_wr_vec), .rd_wr_pred(rd_wr_pred), .done(done)
  );

  vseq_wb #(.REG_W(REG_W), .ELEM_W(ELEM_W)) u_wb (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_last(rd_last),
    .rd_wr_vec(rd_wr_vec), .rd_wr_pred(rd_wr_pred), .rd_dst(rd_dst),
    .rd_elem(rd_elem), .vrf_we(vrf_we), .vrf_wr_reg(vrf_wr_reg),
    .vrf_wr_elem(vrf_wr_elem), .prf_we(prf_we), .prf_wr_reg(prf_wr_reg),
    .prf_wr_elem(prf_wr_elem), .wb_last(wb_last)
  );
endmodule

// File: rtl/vseq_checker.sv
module vseq_checker #(
  parameter int ELEM_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_ready,
  input logic              rd_valid,
  input logic [ELEM_W-1:0] rd_elem,
  input logic              vrf_we,
  input logic [ELEM_W-1:0] vrf_wr_elem,
  input logic              prf_we,
  input logic [ELEM_W-1:0] prf_wr_elem,
  input logic              done
);
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !instr_ready);

  a_r3_elem_step: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_valid)) |-> (rd_elem == $past(rd_elem) + 1'b1));

  a_r4_vec_wb_follows_read: assert property (@(posedge clk) disable iff (rst)
    vrf_we |-> ($past(rd_valid) && vrf_wr_elem == $past(rd_elem)));

  a_r6_pred_wb_follows_read: assert property (@(posedge clk) disable iff (rst)
    prf_we |-> ($past(rd_valid) && prf_wr_elem == $past(rd_elem)));

  a_r8_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    instr_ready |-> !(vrf_we || prf_we || rd_valid));

  a_r10_one_file: assert property (@(posedge clk) disable iff (rst)
    $onehot0({vrf_we, prf_we}));
endmodule

bind vec_sequencer vseq_checker #(.ELEM_W(ELEM_W)) u_vseq_checker (
  .clk(clk), .rst(rst), .instr_ready(instr_ready), .rd_valid(rd_valid),
  .rd_elem(rd_elem), .vrf_we(vrf_we), .vrf_wr_elem(vrf_wr_elem),
  .prf_we(prf_we), .prf_wr_elem(prf_wr_elem), .done(done)
);

// File: tb/test_vec_sequencer.sv
`timescale 1ns/1ps
module test_vec_sequencer;
  localparam int NV = 6, NS = 6, NP = 6, NE = 32;
  localparam int K_NONE = 0, K_VV = 1, K_VS = 2, K_PV1 = 3, K_PV2 = 4,
                 K_PP = 5, K_LD = 6, K_ST = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic        instr_ready, rd_valid, rd_src_pred, lane_scalar, srf_rd_en;
  logic [4:0]  rd_elem, vrf_wr_elem, prf_wr_elem;
  logic [2:0]  rd_reg1, rd_reg2, srf_rd_reg, vrf_wr_reg, prf_wr_reg;
  logic [7:0]  lane_op;
  logic        vrf_we, prf_we, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vec_sequencer i_vec_sequencer (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .instr_ready(instr_ready), .rd_valid(rd_valid), .rd_elem(rd_elem),
    .rd_reg1(rd_reg1), .rd_reg2(rd_reg2), .rd_src_pred(rd_src_pred),
    .lane_op(lane_op), .lane_scalar(lane_scalar), .srf_rd_en(srf_rd_en),
    .srf_rd_reg(srf_rd_reg), .vrf_we(vrf_we), .vrf_wr_reg(vrf_wr_reg),
    .vrf_wr_elem(vrf_wr_elem), .prf_we(prf_we), .prf_wr_reg(prf_wr_reg),
    .prf_wr_elem(prf_wr_elem), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int kind_of(input int op);
    case (op)
      'h00: return K_LD;
      'h01: return K_ST;
      'h02, 'h03, 'h04, 'h07, 'h08, 'h09, 'h0A, 'h0B, 'h10: return K_VV;
      'h05, 'h06, 'h15, 'h16: return K_VS;
      'h0C, 'h0D, 'h0E: return K_PV1;
      'h0F, 'h18, 'h19, 'h1A: return K_PV2;
      'h14, 'h17: return K_PP;
      default: return K_NONE;
    endcase
  endfunction

  function automatic bit is_legal(input int k, input int a, input int b, input int c);
    case (k)
      K_VV:       return a < NV && b < NV && c < NV;
      K_VS:       return a < NV && b < NV && c < NS;
      K_PV1:      return a < NP && b < NV;
      K_PV2:      return a < NP && b < NV && c < NV;
      K_PP:       return a < NP && b < NP && c < NP;
      K_LD, K_ST: return a < NV && b < NE;
      default:    return 1'b0;
    endcase
  endfunction

  task automatic run_instr(input int op, input int a, input int b, input int c);
    int  k     = kind_of(op);
    bit  lg    = is_legal(k, a, b, c);
    bit  sgl   = (k == K_LD) || (k == K_ST);
    bit  pred  = (k == K_PV1) || (k == K_PV2) || (k == K_PP);
    bit  vwr   = (k == K_VV) || (k == K_VS) || (k == K_LD);
    int  first = sgl ? b : 0;
    int  nexp  = sgl ? 1 : NE;
    int  dk    = sgl ? 3 : 34;
    int  er1   = sgl ? a : b;
    int  er2   = (k == K_VV || k == K_PV2 || k == K_PP) ? c : 0;
    int  nrd = 0, nsrf = 0, nv = 0, np = 0, mis_rd = 0, mis_s = 0, mis_w = 0;
    int  busy = 0, act = 0, done_k = -1;
    @(negedge clk);
    chk(instr_ready == 1'b1, "R2 ready before issue", instr_ready, 1);
    instr_valid = 1'b1;
    instr_word  = {c[7:0], b[7:0], a[7:0], op[7:0]};
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
    if (!lg) begin
      for (int i = 0; i < 6; i++) begin
        if (i > 0) begin @(posedge clk); @(negedge clk); end
        if (rd_valid || vrf_we || prf_we || done || srf_rd_en || !instr_ready) act++;
      end
      chk(act == 0, $sformatf("R9 discard op=%0h a=%0d b=%0d c=%0d", op, a, b, c), act, 0);
      return;
    end
    for (int t = 0; t <= 40; t++) begin
      if (t > 0) begin @(posedge clk); @(negedge clk); end
      if (rd_valid) begin
        if (rd_elem != 5'(first + nrd) || rd_reg1 != 3'(er1) || rd_reg2 != 3'(er2) ||
            lane_op != 8'(op) || lane_scalar != (k == K_VS) ||
            rd_src_pred != (k == K_PP) || t != nrd + 1) mis_rd++;
        nrd++;
      end
      if (srf_rd_en) begin
        if (t != 1 || srf_rd_reg != 3'(c)) mis_s++;
        nsrf++;
      end
      if (vrf_we) begin
        if (vrf_wr_reg != 3'(a) || vrf_wr_elem != 5'(first + nv) || t != nv + 2) mis_w++;
        nv++;
      end
      if (prf_we) begin
        if (prf_wr_reg != 3'(a) || prf_wr_elem != 5'(first + np) || t != np + 2) mis_w++;
        np++;
      end
      if (instr_ready && !done) busy++;
      if (done) begin done_k = t; break; end
    end
    chk(nrd == nexp, $sformatf("%s read count op=%0h", sgl ? "R7" : "R3", op), nrd, nexp);
    chk(mis_rd == 0, $sformatf("%s read fields op=%0h", sgl ? "R7" : (k == K_VS ? "R5" : (pred ? "R6" : "R4")), op), mis_rd, 0);
    chk(nsrf == (k == K_VS ? 1 : 0), $sformatf("R5 scalar reads op=%0h", op), nsrf, k == K_VS ? 1 : 0);
    chk(mis_s == 0, $sformatf("R5 scalar index/timing op=%0h", op), mis_s, 0);
    chk(nv == (vwr ? nexp : 0), $sformatf("R4 vector writes op=%0h", op), nv, vwr ? nexp : 0);
    chk(np == (pred ? NE : 0), $sformatf("R6 predicate writes op=%0h", op), np, pred ? NE : 0);
    chk(mis_w == 0, $sformatf("R4 write address/timing op=%0h", op), mis_w, 0);
    chk(done_k == dk, $sformatf("R8 done latency op=%0h", op), done_k, dk);
    chk(busy == 0, $sformatf("R2 ready while busy op=%0h", op), busy, 0);
    @(negedge clk);
    chk(done == 1'b0, $sformatf("R8 done one cycle op=%0h", op), done, 0);
    chk(vrf_we == 1'b0 && prf_we == 1'b0, $sformatf("R10 quiet after op=%0h", op), vrf_we + prf_we, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(instr_ready == 1'b1, "R1 ready after reset", instr_ready, 1);
    chk(!rd_valid && !srf_rd_en, "R1 no read after reset", rd_valid + srf_rd_en, 0);
    chk(!vrf_we && !prf_we && !done, "R1 no write/done after reset", vrf_we + prf_we + done, 0);

    for (int op = 0; op < 256; op++)
      run_instr(op, op % NV, (op + 1) % NV, (op + 2) % NV);

    run_instr('h02, 5, 4, 3);
    run_instr('h00, 5, 31, 0);
    run_instr('h01, 0, 0, 7);
    run_instr('h16, 5, 5, 5);
    run_instr('h17, 5, 0, 5);
    run_instr('h02, 6, 0, 1);
    run_instr('h03, 0, 6, 1);
    run_instr('h05, 0, 1, 6);
    run_instr('h0F, 6, 0, 0);
    run_instr('h14, 0, 0, 6);
    run_instr('h0C, 1, 6, 0);
    run_instr('h00, 1, 32, 0);
    run_instr('h01, 6, 0, 0);
    run_instr('h1B, 0, 0, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule